// File: doc/BRIEF.md
# Transactional Region Nesting Controller

This block tracks how deep a processor front end sits inside hardware transactional regions and decides where execution resumes when a region is abandoned. Each begin-transaction event supplies the address of the instruction that follows the begin, a signed relative immediate in a short (16-bit) or long (32-bit) form, the current addressing mode and the code-segment limit. Only the outermost begin computes a fallback target, checks it and saves it. Nested begins only deepen the nesting count.

An abort empties the nesting state. An abort is caused either by a begin that would exceed the nesting limit or by an external abort request while a region is open. The abort redirects the program counter to the saved fallback target and delivers a status word for the accumulator in the same cycle. An outermost begin whose target is illegal for the current mode raises a general-protection fault and leaves the block idle. All outputs are registered and appear one clock after the event that causes them.

Top module: `txn_nest_ctrl`

## Requirements
- R1: After reset, nestCount is 0, txnActive is 0, and checkpointPulse, gpFault, redirectValid and statusValid are all 0.
- R2: A begin at depth 0 with a legal target sets nestCount to 1 and txnActive to 1. It also pulses checkpointPulse for one cycle. fallbackPc becomes nextPc plus the sign-extended immediate, where offsetWide=1 selects offset[31:0] and offsetWide=0 selects offset[15:0].
- R3: A begin at a depth between 1 and MAX_NEST-1 adds one to nestCount. It leaves fallbackPc unchanged, gives no checkpointPulse and performs no address check.
- R4: A begin when nestCount equals MAX_NEST does not increment the count. It starts abort processing with status bit 1 (nesting overflow) set.
- R5: In 64-bit mode (mode=2'd2), an outermost target whose bits ADDR_W-1 down to VA_BITS-1 are not all equal gives a one-cycle gpFault. nestCount stays 0, txnActive stays 0, no checkpointPulse is issued and fallbackPc is unchanged.
- R6: In 32-bit mode (mode=2'd1, and also 2'd3), the target is the 32-bit wrapped sum, zero-extended. A target above csLimit gives gpFault and no entry.
- R7: In 16-bit mode (mode=2'd0), a target above 0xFFFF or above csLimit gives gpFault and no entry.
- R8: Abort processing gives, one cycle later, a one-cycle redirectValid with redirectPc equal to the fallbackPc saved by the outermost begin. statusValid is high in that same cycle. nestCount returns to 0 and txnActive to 0.
- R9: abortReq while txnActive is 1 starts abort processing with status bit 0 (external abort) set. abortReq while txnActive is 0 has no effect.
- R10: Status bit 2 is set when the aborted region was nested (nestCount above 1). An abort takes priority over a begin in the same cycle, and that begin is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| beginValid | input | 1 | Begin-transaction event |
| nextPc | input | ADDR_W | Address of the instruction after the begin |
| offset | input | 32 | Relative immediate (low 16 bits used in short form) |
| offsetWide | input | 1 | 1 = 32-bit immediate, 0 = 16-bit immediate |
| mode | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = treated as 32-bit |
| csLimit | input | 32 | Code-segment limit for non-64-bit modes |
| abortReq | input | 1 | External abort request (conflict, capacity) |
| nestCount | output | CNT_W | Current nesting depth |
| txnActive | output | 1 | A transactional region is open |
| fallbackPc | output | ADDR_W | Saved fallback target |
| checkpointPulse | output | 1 | Request to checkpoint registers and memory |
| gpFault | output | 1 | General-protection fault, error code 0 |
| redirectValid | output | 1 | Program-counter redirect strobe |
| redirectPc | output | ADDR_W | Redirect target |
| statusValid | output | 1 | Accumulator status update strobe |
| statusWord | output | STAT_W | Abort status (bit0 external, bit1 overflow, bit2 nested) |

## Verification
The bench builds the block with MAX_NEST=3, ADDR_W=64 and VA_BITS=48. The small depth makes the overflow abort reachable after three begins, and it lets the nested status bit be seen both on an overflow abort and on an external abort. The 48-bit virtual width puts the canonical boundary at bit 47, so targets just past 0x0000_7FFF_FFFF_FFFF and at 0xFFFF_8000_0000_0000 exercise both sides of the 64-bit check. The 16-bit and 32-bit limit checks are also exercised at their edges.

// File: rtl/txn_nest_pkg.sv
package txn_nest_pkg;

  typedef enum logic [1:0] {
    MODE_16 = 2'd0,
    MODE_32 = 2'd1,
    MODE_64 = 2'd2,
    MODE_RSV = 2'd3
  } addr_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchTarget;
    logic doAbort;
    logic ovfCause;
    logic extCause;
    logic deepCause;
  } txn_strobe_t;

  localparam int ST_EXT_BIT  = 0;
  localparam int ST_OVF_BIT  = 1;
  localparam int ST_DEEP_BIT = 2;

endpackage

// File: rtl/txn_nest_dp.sv
module txn_nest_dp
  import txn_nest_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48,
  parameter int STAT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [31:0]       offset,
  input  logic              offsetWide,
  input  logic [1:0]        mode,
  input  logic [31:0]       csLimit,
  input  txn_strobe_t       strobes,
  output logic              addrFault,
  output logic [ADDR_W-1:0] fallbackPc,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              statusValid,
  output logic [STAT_W-1:0] statusWord
);

  localparam int HI_W = ADDR_W - VA_BITS + 1;

  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] sumFull;
  logic [31:0]       sumLow;
  logic [ADDR_W-1:0] target;
  logic              canonOk;
  logic              limitBad;
  logic              rangeBad16;

  always_comb begin
    if (offsetWide) immExt = {{(ADDR_W-32){offset[31]}}, offset};
    else            immExt = {{(ADDR_W-16){offset[15]}}, offset[15:0]};
    sumFull = nextPc + immExt;
    sumLow  = nextPc[31:0] + immExt[31:0];
  end

  generate
    if (VA_BITS < ADDR_W) begin : g_canon
      logic [HI_W-1:0] upperBits;
      assign upperBits = sumFull[ADDR_W-1:VA_BITS-1];
      assign canonOk   = (&upperBits) | ~(|upperBits);
    end else begin : g_flat
      assign canonOk = 1'b1;
    end
  endgenerate

  always_comb begin
    limitBad   = sumLow > csLimit;
    rangeBad16 = |sumLow[31:16];
    target     = {{(ADDR_W-32){1'b0}}, sumLow};
    addrFault  = limitBad;
    unique case (addr_mode_e'(mode))
      MODE_64: begin
        target    = sumFull;
        addrFault = ~canonOk;
      end
      MODE_16:  addrFault = limitBad | rangeBad16;
      default:  addrFault = limitBad;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallbackPc    <= '0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      statusValid   <= 1'b0;
      statusWord    <= '0;
    end else begin
      redirectValid <= strobes.doAbort;
      statusValid   <= strobes.doAbort;
      if (strobes.latchTarget) fallbackPc <= target;
      if (strobes.doAbort) begin
        redirectPc              <= fallbackPc;
        statusWord              <= '0;
        statusWord[ST_EXT_BIT]  <= strobes.extCause;
        statusWord[ST_OVF_BIT]  <= strobes.ovfCause;
        statusWord[ST_DEEP_BIT] <= strobes.deepCause;
      end
    end
  end

endmodule

// File: rtl/txn_nest_fsm.sv
module txn_nest_fsm
  import txn_nest_pkg::*;
#(
  parameter int MAX_NEST = 7,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beginValid,
  input  logic             abortReq,
  input  logic             addrFault,
  output txn_strobe_t      strobes,
  output logic [CNT_W-1:0] nestCount,
  output logic             txnActive,
  output logic             checkpointPulse,
  output logic             gpFault
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_NEST);

  logic atMax, idle, extHit, ovfHit, abortNow, outerBegin, innerBegin;

  always_comb begin
    atMax      = nestCount == MAX_C;
    idle       = nestCount == '0;
    extHit     = abortReq & txnActive;
    ovfHit     = beginValid & atMax & ~idle;
    abortNow   = extHit | ovfHit;
    outerBegin = beginValid & idle & ~abortNow;
    innerBegin = beginValid & ~idle & ~atMax & ~abortNow;

    strobes.latchTarget = outerBegin & ~addrFault;
    strobes.doAbort     = abortNow;
    strobes.ovfCause    = ovfHit;
    strobes.extCause    = extHit;
    strobes.deepCause   = nestCount > CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nestCount       <= '0;
      txnActive       <= 1'b0;
      checkpointPulse <= 1'b0;
      gpFault         <= 1'b0;
    end else begin
      checkpointPulse <= strobes.latchTarget;
      gpFault         <= outerBegin & addrFault;
      if (abortNow) begin
        nestCount <= '0;
        txnActive <= 1'b0;
      end else if (strobes.latchTarget) begin
        nestCount <= CNT_W'(1);
        txnActive <= 1'b1;
      end else if (innerBegin) begin
        nestCount <= nestCount + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
  import txn_nest_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int VA_BITS  = 48,
  parameter int MAX_NEST = 7,
  parameter int STAT_W   = 32,
  localparam int CNT_W   = $clog2(MAX_NEST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              beginValid,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [31:0]       offset,
  input  logic              offsetWide,
  input  logic [1:0]        mode,
  input  logic [31:0]       csLimit,
  input  logic              abortReq,
  output logic [CNT_W-1:0]  nestCount,
  output logic              txnActive,
  output logic [ADDR_W-1:0] fallbackPc,
  output logic              checkpointPulse,
  output logic              gpFault,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              statusValid,
  output logic [STAT_W-1:0] statusWord
);

  txn_strobe_t strobes;
  logic        addrFault;

  txn_nest_fsm #(.MAX_NEST(MAX_NEST), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rstN(rstN), .beginValid(beginValid), .abortReq(abortReq),
    .addrFault(addrFault), .strobes(strobes), .nestCount(nestCount),
    .txnActive(txnActive), .checkpointPulse(checkpointPulse), .gpFault(gpFault)
  );

  txn_nest_dp #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .STAT_W(STAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .nextPc(nextPc), .offset(offset),
    .offsetWide(offsetWide), .mode(mode), .csLimit(csLimit), .strobes(strobes),
    .addrFault(addrFault), .fallbackPc(fallbackPc), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .statusValid(statusValid), .statusWord(statusWord)
  );

endmodule

// File: rtl/txn_nest_ctrl_chk.sv
module txn_nest_ctrl_chk #(
  parameter int ADDR_W   = 64,
  parameter int MAX_NEST = 7,
  parameter int CNT_W    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  nestCount,
  input logic              txnActive,
  input logic [ADDR_W-1:0] fallbackPc,
  input logic              checkpointPulse,
  input logic              gpFault,
  input logic              redirectValid,
  input logic              statusValid
);

  // R1
  active_matches_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnActive == (nestCount != '0));

  // R2
  checkpoint_on_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    checkpointPulse |-> (txnActive && nestCount == CNT_W'(1)));

  // R3
  depth_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    nestCount <= CNT_W'(MAX_NEST));

  // R3
  fallback_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txnActive && $past(txnActive)) |-> $stable(fallbackPc));

  // R5
  fault_no_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> (!txnActive && !checkpointPulse));

  // R8
  redirect_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (statusValid && !txnActive && nestCount == '0));

  // R9
  redirect_needs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(txnActive));

endmodule

bind txn_nest_ctrl txn_nest_ctrl_chk #(
  .ADDR_W(ADDR_W), .MAX_NEST(MAX_NEST), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .nestCount(nestCount), .txnActive(txnActive),
  .fallbackPc(fallbackPc), .checkpointPulse(checkpointPulse), .gpFault(gpFault),
  .redirectValid(redirectValid), .statusValid(statusValid)
);

// File: tb/txn_nest_ctrl_bench.sv
module txn_nest_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 64;
  localparam int VA_BITS  = 48;
  localparam int MAX_NEST = 3;
  localparam int STAT_W   = 32;
  localparam int CNT_W    = $clog2(MAX_NEST + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic beginValid = 1'b0;
  logic [ADDR_W-1:0] nextPc = '0;
  logic [31:0] offset = '0;
  logic offsetWide = 1'b0;
  logic [1:0] mode = 2'd2;
  logic [31:0] csLimit = 32'hFFFF_FFFF;
  logic abortReq = 1'b0;
  logic [CNT_W-1:0] nestCount;
  logic txnActive, checkpointPulse, gpFault, redirectValid, statusValid;
  logic [ADDR_W-1:0] fallbackPc, redirectPc;
  logic [STAT_W-1:0] statusWord;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_nest_ctrl #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .MAX_NEST(MAX_NEST),
                  .STAT_W(STAT_W)) u_txn_nest_ctrl (
    .clk(clk), .rstN(rstN), .beginValid(beginValid), .nextPc(nextPc),
    .offset(offset), .offsetWide(offsetWide), .mode(mode), .csLimit(csLimit),
    .abortReq(abortReq), .nestCount(nestCount), .txnActive(txnActive),
    .fallbackPc(fallbackPc), .checkpointPulse(checkpointPulse), .gpFault(gpFault),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .statusValid(statusValid), .statusWord(statusWord)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one event for one cycle; outputs checked after the registering edge
  task automatic pulse(logic b, logic a, logic [63:0] pc, logic [31:0] off,
                       logic wide, logic [1:0] md, logic [31:0] lim);
    @(negedge clk);
    beginValid = b; abortReq = a; nextPc = pc; offset = off;
    offsetWide = wide; mode = md; csLimit = lim;
    @(negedge clk);
    beginValid = 1'b0; abortReq = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1", "nestCount", 64'(nestCount), 64'd0);
    chk("R1", "txnActive", 64'(txnActive), 64'd0);
    chk("R1", "pulses", {60'd0, checkpointPulse, gpFault, redirectValid, statusValid}, 64'd0);
  endtask

  task automatic test_nest_overflow();
    pulse(1, 0, 64'h1000, 32'h0000_FFF0, 0, 2'd2, 32'hFFFF_FFFF);
    chk("R2", "count", 64'(nestCount), 64'd1);
    chk("R2", "active", 64'(txnActive), 64'd1);
    chk("R2", "checkpoint", 64'(checkpointPulse), 64'd1);
    chk("R2", "fallback short imm", fallbackPc, 64'h0FF0);
    pulse(1, 0, 64'h5000, 32'h0000_0100, 1, 2'd2, 32'hFFFF_FFFF);
    chk("R3", "count 2", 64'(nestCount), 64'd2);
    chk("R3", "fallback held", fallbackPc, 64'h0FF0);
    chk("R3", "no checkpoint", 64'(checkpointPulse), 64'd0);
    pulse(1, 0, 64'h0000_7FFF_FFFF_FFF0, 32'h20, 1, 2'd2, 32'hFFFF_FFFF);
    chk("R3", "inner no check", {nestCount == 2'd3, gpFault}, 2'b10);
    pulse(1, 0, 64'h6000, 32'h4, 1, 2'd2, 32'hFFFF_FFFF);
    chk("R4", "redirect", 64'(redirectValid), 64'd1);
    chk("R8", "redirectPc", redirectPc, 64'h0FF0);
    chk("R8", "statusValid", 64'(statusValid), 64'd1);
    chk("R4", "status ovf+deep", 64'(statusWord), 64'h6);
    chk("R8", "count cleared", {nestCount, txnActive}, '0);
    @(negedge clk);
    chk("R8", "redirect one cycle", 64'(redirectValid), 64'd0);
  endtask

  task automatic test_ignored_abort();
    pulse(0, 1, 64'h0, 32'h0, 0, 2'd2, 32'hFFFF_FFFF);
    chk("R9", "no redirect when idle", {redirectValid, statusValid}, 2'b00);
    chk("R9", "idle count", {nestCount, txnActive}, '0);
  endtask

  task automatic test_canonical();
    pulse(1, 0, 64'h0000_7FFF_FFFF_FFF0, 32'h20, 1, 2'd2, 32'hFFFF_FFFF);
    chk("R5", "gpFault", 64'(gpFault), 64'd1);
    chk("R5", "no entry", {nestCount, txnActive, checkpointPulse}, '0);
    chk("R5", "fallback unchanged", fallbackPc, 64'h0FF0);
    pulse(1, 0, 64'hFFFF_8000_0000_0010, 32'hFFFF_FFF0, 1, 2'd2, 32'hFFFF_FFFF);
    chk("R5", "canonical high ok", {gpFault, txnActive}, 2'b01);
    chk("R2", "fallback long imm", fallbackPc, 64'hFFFF_8000_0000_0000);
    pulse(0, 1, 64'h0, 32'h0, 0, 2'd2, 32'hFFFF_FFFF);
    chk("R9", "ext abort redirect", redirectPc, 64'hFFFF_8000_0000_0000);
    chk("R9", "ext status", 64'(statusWord), 64'h1);
  endtask

  task automatic test_mode32();
    pulse(1, 0, 64'h100, 32'h200, 1, 2'd1, 32'h2FF);
    chk("R6", "limit fault", {gpFault, txnActive}, 2'b10);
    pulse(1, 0, 64'hABCD_0000_0000_0100, 32'h200, 1, 2'd1, 32'h300);
    chk("R6", "at limit ok", {gpFault, txnActive}, 2'b01);
    chk("R6", "zero-extended", fallbackPc, 64'h300);
    pulse(1, 0, 64'h900, 32'h8, 0, 2'd1, 32'h300);
    chk("R3", "nested in 32", 64'(nestCount), 64'd2);
    pulse(0, 1, 64'h0, 32'h0, 0, 2'd1, 32'h300);
    chk("R10", "deep ext status", 64'(statusWord), 64'h5);
    chk("R8", "redirect 32", redirectPc, 64'h300);
  endtask

  task automatic test_mode16();
    pulse(1, 0, 64'hFFF0, 32'h0020, 0, 2'd0, 32'hFFFF_FFFF);
    chk("R7", "above 0xFFFF", {gpFault, txnActive}, 2'b10);
    pulse(1, 0, 64'h1000, 32'h0010, 0, 2'd0, 32'h0FFF);
    chk("R7", "above limit", {gpFault, txnActive}, 2'b10);
    pulse(1, 0, 64'hFFF0, 32'h000F, 0, 2'd0, 32'hFFFF_FFFF);
    chk("R7", "0xFFFF ok", {gpFault, txnActive}, 2'b01);
    chk("R7", "fallback", fallbackPc, 64'hFFFF);
    pulse(1, 1, 64'h2000, 32'h4, 0, 2'd0, 32'hFFFF_FFFF);
    chk("R10", "abort beats begin", {nestCount, txnActive, redirectValid}, 4'b0001);
    chk("R10", "shallow status", 64'(statusWord), 64'h1);
    chk("R10", "redirect", redirectPc, 64'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_nest_overflow();
    test_ignored_abort();
    test_canonical();
    test_mode32();
    test_mode16();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule